// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block watches a DRAM controller and counts what it does. The controller feeds it a vector of single-cycle event strobes, plus two dedicated strobes that pulse once for each DRAM read and each DRAM write. Software reaches the unit through a plain 64-bit register port, using fixed offsets.

There are eight programmable counters. Each one has a configuration register that holds an enable flag and an event-select mask. A programmable counter advances only while the unit is in the running state. Software enters that state by writing a start command and leaves it by writing an end command. Issuing a start from the stopped state zeroes every programmable counter, which begins a new measurement window. A counter saturates at its top value and raises a full flag.

The two fixed counters, one for reads and one for writes, have their own enable and clear bits. They run whether or not the unit is started. They wrap around and keep a sticky overflow bit.

Top module: `mcperf_unit`

## Requirements
- R1: After a synchronous reset, every register and counter reads zero, `prog_full` is zero and the unit is stopped.
- R2: The configuration register of programmable counter n is at offset 0x8040 + 8n. It stores all 64 written bits and reads them back. Bit 63 is the enable, and bit i (i < 63) selects event strobe i.
- R3: Programmable counter n advances by exactly one in a cycle only when three conditions hold: its enable is set, the unit is running, and at least one strobe selected by its mask is high. Its value reads at 0x8080 + 8n.
- R4: A mask with a field of four adjacent bits set counts a cycle in which any strobe inside that field is high. Strobes just outside the field are not counted.
- R5: Writing 1 to bit 0 of 0x8028 makes the unit run, and reading that offset returns bit 1 = 1 while it runs. Writing 1 to bit 0 of 0x8030 stops it. Stopped counters hold their values.
- R6: A start written while stopped zeroes every programmable counter. A start written while already running changes no counter.
- R7: Programmable counters are CNT_W+1 bits wide (49 by default). They hold at all ones instead of wrapping, and `prog_full[n]` is high exactly while counter n is all ones.
- R8: The free-run enable register is at 0x80C0. Its bit 0 enables the write counter (counts `dram_wr_evt`) and bit 1 enables the read counter (counts `dram_rd_evt`). Both counters ignore the start/end state. The write count reads at 0x80D0 and the read count at 0x80D8.
- R9: Fixed counters wrap modulo 2^CNT_W. Bit CNT_W of their read value is a sticky overflow flag that is set on wrap.
- R10: Writing 0x80C8 with bit 0 set clears the write counter and its overflow flag. Writing it with bit 1 set does the same for the read counter. A clear wins over an event in the same cycle, and the other counter is unaffected.
- R11: `bus_rvalid` and `bus_rdata` follow a read request by one cycle. Unmapped or misaligned offsets read zero, and writes to them change nothing.
- R12: The mode register at 0x8020 stores and returns bit 0. The end-status register at 0x8038 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| evt_strobe | input | EVT_W (63) | One-cycle event strobes from the controller |
| dram_rd_evt | input | 1 | One pulse per DRAM read |
| dram_wr_evt | input | 1 | One pulse per DRAM write |
| prog_full | output | NUM_PROG (8) | Programmable counter n is saturated |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- Two selected strobes firing in the same cycle must add one, not two. A design that summed the hits would report a doubled count.
- A start issued while already running must not zero the counters. A design that cleared on every start would lose a running count.
- A narrow second instance drives a programmable counter past all ones and a fixed counter past its wrap point. A design with the roles swapped would show wrap where saturation belongs, or would drop the overflow flag.
- A clear is issued in the same cycle as a read event. A design that gave the event priority would leave a count of one behind.

// File: rtl/mcperf_pkg.sv
package mcperf_pkg;

  localparam int REG_W  = 64;
  localparam int ADDR_W = 16;
  localparam int EN_BIT = 63;

  // Offsets kept at fixed positions because driver software decodes them.
  localparam logic [ADDR_W-1:0] OFS_MODE  = 16'h8020;
  localparam logic [ADDR_W-1:0] OFS_START = 16'h8028;
  localparam logic [ADDR_W-1:0] OFS_END   = 16'h8030;
  localparam logic [ADDR_W-1:0] OFS_ENDST = 16'h8038;
  localparam logic [ADDR_W-1:0] OFS_CFG0  = 16'h8040;
  localparam logic [ADDR_W-1:0] OFS_VAL0  = 16'h8080;
  localparam logic [ADDR_W-1:0] OFS_FREN  = 16'h80C0;
  localparam logic [ADDR_W-1:0] OFS_FRCLR = 16'h80C8;
  localparam logic [ADDR_W-1:0] OFS_WRCNT = 16'h80D0;
  localparam logic [ADDR_W-1:0] OFS_RDCNT = 16'h80D8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_START, SEL_END, SEL_ENDST, SEL_CFG,
    SEL_VAL, SEL_FREN, SEL_FRCLR, SEL_WRCNT, SEL_RDCNT
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [2:0] idx;
  } reg_hit_t;

  function automatic reg_hit_t decode_addr(logic [ADDR_W-1:0] a, int nprog);
    reg_hit_t h;
    h.sel = SEL_NONE;
    h.idx = a[5:3];
    if (a[2:0] == 3'b000) begin
      if (a >= OFS_CFG0 && a < OFS_CFG0 + 16'(8 * nprog))      h.sel = SEL_CFG;
      else if (a >= OFS_VAL0 && a < OFS_VAL0 + 16'(8 * nprog)) h.sel = SEL_VAL;
      else begin
        case (a)
          OFS_MODE:  h.sel = SEL_MODE;
          OFS_START: h.sel = SEL_START;
          OFS_END:   h.sel = SEL_END;
          OFS_ENDST: h.sel = SEL_ENDST;
          OFS_FREN:  h.sel = SEL_FREN;
          OFS_FRCLR: h.sel = SEL_FRCLR;
          OFS_WRCNT: h.sel = SEL_WRCNT;
          OFS_RDCNT: h.sel = SEL_RDCNT;
          default:   h.sel = SEL_NONE;
        endcase
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/mcperf_regs.sv
module mcperf_regs
  import mcperf_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 48
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                bus_wr,
  input  logic                                bus_rd,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [REG_W-1:0]                    bus_wdata,
  output logic [REG_W-1:0]                    bus_rdata,
  output logic                                bus_rvalid,
  output logic [NUM_PROG-1:0][REG_W-1:0]      cfg_o,
  output logic                                running_o,
  output logic                                restart_o,
  output logic [1:0]                          fren_o,
  output logic [1:0]                          frclr_o,
  input  logic [NUM_PROG-1:0][CNT_W:0]        prog_val_i,
  input  logic [CNT_W:0]                      wr_val_i,
  input  logic [CNT_W:0]                      rd_val_i
);

  reg_hit_t hit;
  logic [NUM_PROG-1:0][REG_W-1:0] cfg_q;
  logic       mode_q;
  logic       running_q;
  logic [1:0] fren_q;
  logic [REG_W-1:0] rd_mux;

  assign hit = decode_addr(bus_addr, NUM_PROG);

  // Start while stopped opens a new window; end stops it.
  assign restart_o = bus_wr && hit.sel == SEL_START && bus_wdata[0] && !running_q;
  assign frclr_o   = (bus_wr && hit.sel == SEL_FRCLR) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      running_q <= 1'b0;
      fren_q    <= 2'b00;
    end else if (bus_wr) begin
      case (hit.sel)
        SEL_MODE:  mode_q <= bus_wdata[0];
        SEL_START: if (bus_wdata[0]) running_q <= 1'b1;
        SEL_END:   if (bus_wdata[0]) running_q <= 1'b0;
        SEL_FREN:  fren_q <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) cfg_q[i] <= '0;
      else if (bus_wr && hit.sel == SEL_CFG && hit.idx == 3'(i)) cfg_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (hit.sel)
      SEL_MODE:  rd_mux = {{(REG_W-1){1'b0}}, mode_q};
      SEL_START: rd_mux = {{(REG_W-2){1'b0}}, running_q, 1'b0};
      SEL_CFG:   rd_mux = cfg_q[hit.idx];
      SEL_VAL:   rd_mux = REG_W'(prog_val_i[hit.idx]);
      SEL_FREN:  rd_mux = {{(REG_W-2){1'b0}}, fren_q};
      SEL_WRCNT: rd_mux = REG_W'(wr_val_i);
      SEL_RDCNT: rd_mux = REG_W'(rd_val_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rdata  <= bus_rd ? rd_mux : '0;
      bus_rvalid <= bus_rd;
    end
  end

  assign cfg_o     = cfg_q;
  assign running_o = running_q;
  assign fren_o    = fren_q;

endmodule

// File: rtl/mcperf_prog_ctr.sv
module mcperf_prog_ctr #(
  parameter int CNT_W = 48,
  parameter int EVT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             restart,
  input  logic [EVT_W-1:0] mask,
  input  logic [EVT_W-1:0] strobe,
  output logic [CNT_W:0]   val_o,
  output logic             full_o
);

  localparam int VW = CNT_W + 1;
  localparam logic [VW-1:0] TOP = '1;

  logic [VW-1:0] cnt_q, cnt_nxt;
  logic          hit;

  // Any number of selected strobes in one cycle adds a single count.
  assign hit = en && run && (|(mask & strobe));

  always_comb begin
    cnt_nxt = cnt_q;
    if (restart)                  cnt_nxt = '0;
    else if (hit && cnt_q != TOP) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      full_o <= (cnt_nxt == TOP);
    end
  end

  assign val_o = cnt_q;

endmodule

// File: rtl/mcperf_free_ctr.sv
module mcperf_free_ctr #(
  parameter int CNT_W = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           clr,
  input  logic           evt,
  output logic [CNT_W:0] val_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en && evt) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) ovf_q <= 1'b1;
    end
  end

  assign val_o = {ovf_q, cnt_q};

endmodule

// File: rtl/mcperf_unit.sv
module mcperf_unit
  import mcperf_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 48,
  parameter int EVT_W    = 63
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [15:0]         bus_addr,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [EVT_W-1:0]    evt_strobe,
  input  logic                dram_rd_evt,
  input  logic                dram_wr_evt,
  output logic [NUM_PROG-1:0] prog_full
);

  logic [NUM_PROG-1:0][REG_W-1:0] cfg;
  logic [NUM_PROG-1:0][CNT_W:0]   prog_val;
  logic [1:0][CNT_W:0]            fix_val;
  logic [1:0]                     fren;
  logic [1:0]                     frclr;
  logic [1:0]                     fix_evt;
  logic                           run_active;
  logic                           restart;
  logic [CNT_W:0]                 wr_fix_val;

  mcperf_regs #(.NUM_PROG(NUM_PROG), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cfg_o(cfg), .running_o(run_active), .restart_o(restart),
    .fren_o(fren), .frclr_o(frclr),
    .prog_val_i(prog_val), .wr_val_i(fix_val[0]), .rd_val_i(fix_val[1])
  );

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
    mcperf_prog_ctr #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_ctr (
      .clk(clk), .rst(rst),
      .en(cfg[i][EN_BIT]), .run(run_active), .restart(restart),
      .mask(cfg[i][EVT_W-1:0]), .strobe(evt_strobe),
      .val_o(prog_val[i]), .full_o(prog_full[i])
    );
  end

  // Slot 0 counts writes, slot 1 counts reads; enable/clear bits match.
  assign fix_evt = {dram_rd_evt, dram_wr_evt};

  for (genvar j = 0; j < 2; j++) begin : g_fix
    mcperf_free_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst),
      .en(fren[j]), .clr(frclr[j]), .evt(fix_evt[j]),
      .val_o(fix_val[j])
    );
  end

  assign wr_fix_val = fix_val[0];

endmodule

// File: rtl/mcperf_unit_chk.sv
module mcperf_unit_chk #(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 48
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [15:0]         bus_addr,
  input logic [1:0]          wdata_lo,
  input logic [63:0]         bus_rdata,
  input logic                bus_rvalid,
  input logic [NUM_PROG-1:0] prog_full,
  input logic                run_active,
  input logic [CNT_W:0]      wr_fix_val
);

  function automatic logic is_mapped(logic [15:0] a);
    if (a[2:0] != 3'b000) return 1'b0;
    if (a >= 16'h8020 && a <= 16'h8038) return 1'b1;
    if (a >= 16'h8040 && a < 16'h8040 + 16'(8 * NUM_PROG)) return 1'b1;
    if (a >= 16'h8080 && a < 16'h8080 + 16'(8 * NUM_PROG)) return 1'b1;
    if (a >= 16'h80C0 && a <= 16'h80D8) return 1'b1;
    return 1'b0;
  endfunction

  logic start_cmd, end_cmd, wclr_cmd;
  assign start_cmd = bus_wr && bus_addr == 16'h8028 && wdata_lo[0];
  assign end_cmd   = bus_wr && bus_addr == 16'h8030 && wdata_lo[0];
  assign wclr_cmd  = bus_wr && bus_addr == 16'h80C8 && wdata_lo[0];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!run_active && prog_full == '0 && !bus_rvalid));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_no_spurious_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !is_mapped(bus_addr)) |=> bus_rdata == 64'd0);

  assert_start_runs_R5: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> run_active);

  assert_end_stops_R5: assert property (@(posedge clk) disable iff (rst)
    end_cmd |=> !run_active);

  assert_wr_clear_R10: assert property (@(posedge clk) disable iff (rst)
    wclr_cmd |=> wr_fix_val == '0);

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_full
    assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (prog_full[i] && !(start_cmd && !run_active)) |=> prog_full[i]);
  end

endmodule

bind mcperf_unit mcperf_unit_chk #(.NUM_PROG(NUM_PROG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[1:0]), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .prog_full(prog_full), .run_active(run_active), .wr_fix_val(wr_fix_val)
);

// File: tb/mcperf_unit_tb.sv
module mcperf_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [62:0] evt = '0;
  logic        rd_evt = 1'b0, wr_evt = 1'b0;
  logic [63:0] rdata_b, rdata_s;
  logic        rvalid_b, rvalid_s;
  logic [7:0]  full_b, full_s;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] EN = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  mcperf_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_rvalid(rvalid_b),
    .evt_strobe(evt), .dram_rd_evt(rd_evt), .dram_wr_evt(wr_evt), .prog_full(full_b)
  );

  // Narrow copy: programmable counters top out at 31, fixed ones wrap at 16.
  mcperf_unit #(.CNT_W(4)) u_small (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .bus_rvalid(rvalid_s),
    .evt_strobe(evt), .dram_rd_evt(rd_evt), .dram_wr_evt(wr_evt), .prog_full(full_s)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [63:0] db, output logic [63:0] ds);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    db = rdata_b; ds = rdata_s;
  endtask

  task automatic pulse(input logic [62:0] e, input logic r, input logic w, input int n);
    @(negedge clk);
    evt = e; rd_evt = r; wr_evt = w;
    repeat (n) @(negedge clk);
    evt = '0; rd_evt = 1'b0; wr_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] b, s;
    reg_rd(16'h8040, b, s); chk("R1 cfg0", b, 0);
    reg_rd(16'h8080, b, s); chk("R1 val0", b, 0);
    reg_rd(16'h8028, b, s); chk("R1 start", b, 0);
    reg_rd(16'h80C0, b, s); chk("R1 fren", b, 0);
    reg_rd(16'h80D0, b, s); chk("R1 wrcnt", b, 0);
    chk("R1 prog_full", 64'(full_b), 0);
  endtask

  task automatic t_cfg();
    logic [63:0] b, s;
    reg_wr(16'h8058, 64'hA5A5_0000_1234_5678);
    reg_rd(16'h8058, b, s); chk("R2 cfg3 readback", b, 64'hA5A5_0000_1234_5678);
    reg_wr(16'h8078, 64'h7FFF_FFFF_FFFF_FFFF);
    reg_rd(16'h8078, b, s); chk("R2 cfg7 readback", b, 64'h7FFF_FFFF_FFFF_FFFF);
    reg_wr(16'h8058, 64'd0);
    reg_wr(16'h8078, 64'd0);
  endtask

  task automatic t_unmapped();
    logic [63:0] b, s;
    reg_wr(16'h8044, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_rd(16'h8040, b, s); chk("R11 misaligned write ignored", b, 0);
    reg_rd(16'h8044, b, s); chk("R11 misaligned read zero", b, 0);
    reg_wr(16'h80E0, 64'h1234);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 16'h80E0;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 rvalid", 64'(rvalid_b), 1);
    chk("R11 unmapped read zero", rdata_b, 0);
    @(negedge clk);
    chk("R11 rvalid drops", 64'(rvalid_b), 0);
  endtask

  task automatic t_mode();
    logic [63:0] b, s;
    reg_wr(16'h8020, 64'd1);
    reg_rd(16'h8020, b, s); chk("R12 mode readback", b, 1);
    reg_rd(16'h8038, b, s); chk("R12 end status", b, 0);
  endtask

  task automatic t_count();
    logic [63:0] b, s;
    reg_wr(16'h8040, EN | 64'h20);
    reg_wr(16'h8048, EN | 64'h220);
    reg_wr(16'h8050, 64'h20);
    reg_wr(16'h8028, 64'd1);
    reg_rd(16'h8028, b, s); chk("R5 active bit", b, 2);
    pulse(63'h20, 1'b0, 1'b0, 7);
    pulse(63'h220, 1'b0, 1'b0, 3);
    pulse(63'(1) << 20, 1'b0, 1'b0, 4);
    reg_rd(16'h8080, b, s); chk("R3 single select", b, 10);
    reg_rd(16'h8088, b, s); chk("R3 two hits add one", b, 10);
    reg_rd(16'h8090, b, s); chk("R3 disabled counter", b, 0);
  endtask

  task automatic t_group();
    logic [63:0] b, s;
    reg_wr(16'h8060, EN | (64'hF << 26));
    pulse(63'(1) << 28, 1'b0, 1'b0, 3);
    pulse(63'(1) << 26, 1'b0, 1'b0, 2);
    pulse(63'(1) << 30, 1'b0, 1'b0, 1);
    pulse(63'(1) << 25, 1'b0, 1'b0, 1);
    pulse((63'(1) << 26) | (63'(1) << 29), 1'b0, 1'b0, 2);
    reg_rd(16'h80A0, b, s); chk("R4 four-bit field", b, 7);
  endtask

  task automatic t_restart();
    logic [63:0] b, s;
    reg_wr(16'h8030, 64'd1);
    reg_rd(16'h8028, b, s); chk("R5 inactive after end", b, 0);
    pulse(63'h20, 1'b0, 1'b0, 4);
    reg_rd(16'h8080, b, s); chk("R5 frozen when stopped", b, 10);
    reg_wr(16'h8028, 64'd1);
    reg_rd(16'h8080, b, s); chk("R6 restart zeroes val0", b, 0);
    reg_rd(16'h80A0, b, s); chk("R6 restart zeroes val4", b, 0);
    pulse(63'h20, 1'b0, 1'b0, 2);
    reg_wr(16'h8028, 64'd1);
    reg_rd(16'h8080, b, s); chk("R6 start while running keeps", b, 2);
  endtask

  task automatic t_saturate();
    logic [63:0] b, s;
    reg_wr(16'h8030, 64'd1);
    reg_wr(16'h8028, 64'd1);
    pulse(63'h20, 1'b0, 1'b0, 40);
    reg_rd(16'h8080, b, s);
    chk("R7 small saturates", s, 31);
    chk("R7 wide keeps counting", b, 40);
    chk("R7 small full flag", 64'(full_s[0]), 1);
    chk("R7 wide not full", 64'(full_b[0]), 0);
    reg_wr(16'h8030, 64'd1);
    reg_wr(16'h8028, 64'd1);
    reg_rd(16'h8080, b, s);
    chk("R7 restart clears saturated", s, 0);
    chk("R7 full drops", 64'(full_s[0]), 0);
  endtask

  task automatic t_fixed();
    logic [63:0] b, s;
    pulse('0, 1'b0, 1'b1, 3);
    reg_rd(16'h80D0, b, s); chk("R8 disabled write counter", b, 0);
    reg_wr(16'h80C0, 64'd1);
    pulse('0, 1'b0, 1'b1, 5);
    pulse('0, 1'b1, 1'b0, 4);
    reg_rd(16'h80D0, b, s); chk("R8 write counter", b, 5);
    reg_rd(16'h80D8, b, s); chk("R8 read counter disabled", b, 0);
    reg_wr(16'h80C0, 64'd3);
    reg_wr(16'h8030, 64'd1);
    pulse('0, 1'b1, 1'b0, 6);
    reg_rd(16'h80D8, b, s); chk("R8 read counter while stopped", b, 6);
    reg_rd(16'h80C0, b, s); chk("R8 enable readback", b, 3);
  endtask

  task automatic t_wrap_clear();
    logic [63:0] b, s;
    reg_wr(16'h80C8, 64'd1);
    reg_rd(16'h80D0, b, s);
    chk("R10 write clear wide", b, 0);
    chk("R10 write clear small", s, 0);
    reg_rd(16'h80D8, b, s); chk("R10 read counter untouched", b, 6);
    pulse('0, 1'b0, 1'b1, 18);
    reg_rd(16'h80D0, b, s);
    chk("R9 small wrap with overflow", s, 64'h12);
    chk("R9 wide no wrap", b, 18);
    reg_wr(16'h80C8, 64'd1);
    reg_rd(16'h80D0, b, s); chk("R10 overflow cleared", s, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 16'h80C8; bus_wdata = 64'd2; rd_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; rd_evt = 1'b0;
    reg_rd(16'h80D8, b, s); chk("R10 clear beats event", b, 0);
    reg_rd(16'h80C8, b, s); chk("R10 clear reg reads zero", b, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg();
    t_unmapped();
    t_mode();
    t_count();
    t_group();
    t_restart();
    t_saturate();
    t_fixed();
    t_wrap_clear();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule